// File: doc/BRIEF.md
# Three-Level Virtual Address Translator

This block turns a 64-bit virtual address into a physical address plus a read/write/execute permission set. It can reach the result in two ways. A kernel-only superpage window maps directly, with one address bit moved. Every other canonical address is resolved by walking a three-level page table held in memory. A caller pulses `start` with the address, the access kind, the current mode and the table base. Some cycles later the block raises `done` for one cycle. At that point `pa`, `prot` and `fault` hold the result, and they stay there until the next walk completes.

Table entries are read through a 64-bit request/response port with valid/ready rules. A request (`mem_req_valid`, `mem_req_addr`) stays asserted with a stable address until the cycle in which `mem_req_ready` is high. Only one request is outstanding at a time. The block raises `mem_rsp_ready` only while it waits for an entry, and it takes `mem_rsp_data` in the cycle in which `mem_rsp_valid` and `mem_rsp_ready` are both high. The memory side may stall either channel for any number of cycles. Pages are 8 KB, so 43 virtual address bits are implemented.

Top module: `vat_walker`

## Requirements
- R1: An address whose bits 63:42 are not all equal is non-canonical. It completes with fault code 1 (access violation) and issues no memory request.
- R2: A canonical address with bit 63 set and bits 42:41 equal to binary 10 is in the superpage. In mode 0 (kernel) it completes with fault code 0 and `prot` = 3'b111, where bit 0 is read, bit 1 is write and bit 2 is execute. `pa` is virtual bits 39:0 with virtual bit 40 placed at physical bit 43. No memory request is made.
- R3: A superpage access in any mode other than 0 completes with fault code 1.
- R4: The walk reads three 8-byte entries. The first is at `ptbr` + 8*va[42:33], the second at base2 + 8*va[32:23] and the third at base3 + 8*va[22:13]. Each next base is entry bits 63:32 shifted left by 13.
- R5: An entry at any level with bit 0 (valid) clear ends the walk with fault code 2 (translation not valid). No further requests follow it.
- R6: A level-1 or level-2 entry with bit 8 clear ends the walk with fault code 1.
- R7: `acc` encodes the access: 0 is a probe, 1 is read, 2 is write, 3 is execute. At the leaf, entry bit 8+mode grants read and execute, and entry bit 12+mode grants write. If the access needs a permission that is not granted, the fault code is 1. On success the fault code is 0 and `pa` = (leaf bits 63:32 << 13) | va[12:0].
- R8: Leaf bits 1, 2 and 3 remove read, write and execute from `prot`. If the needed permission is then missing, the fault code is 5 for execute, 4 for write and 3 for read, checked in that order.
- R9: A probe (acc 0) that reaches a valid leaf always completes with fault code 0. `prot` then shows the granted permissions after the removals of R8.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold unchanged into the next cycle.
- R11: `done` is high for exactly one cycle per walk. A `start` pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (taken only when idle) |
| va | input | 64 | Virtual address |
| acc | input | 2 | Access kind: 0 probe, 1 read, 2 write, 3 execute |
| mode | input | 2 | Current mode index, 0 is kernel |
| ptbr | input | 64 | Physical base of the level-1 table |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 64 | Translated physical address |
| prot | output | 3 | Granted permissions {execute, write, read} |
| fault | output | 3 | 0 ok, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Walker waits for entry data |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The hardest situation to reach is a stall at the request channel in the middle of a walk, while a second `start` is also being pulsed at the busy walker. The memory model in the bench drops `mem_req_ready` on a repeating pattern that falls on different walk levels from one test to the next. A monitor compares every stalled request with the one in the following cycle. One scenario pulses a non-canonical `start` during a walk and expects the first walk's normal three-read result. The priority of fault-on codes is reached by loading a leaf entry with one removal bit at a time.

// File: rtl/vat_pkg.sv
package vat_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } vat_fault_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } vat_state_e;

  // permission vector layout: [0] read, [1] write, [2] execute
  function automatic logic [2:0] acc_to_need(input logic [1:0] a);
    case (a)
      2'd1:    return 3'b001;
      2'd2:    return 3'b010;
      2'd3:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/vat_region.sv
module vat_region #(
  parameter int VA_W        = 64,
  parameter int IMPL_BITS   = 43,
  parameter int SP_TAG_LO   = 41,
  parameter int SP_LOW_BITS = 40,
  parameter int SP_RELOC    = 43
) (
  input  logic [VA_W-1:0] va,
  output logic            canon,
  output logic            sp_hit,
  output logic [VA_W-1:0] sp_pa
);
  localparam int HI_W = VA_W - IMPL_BITS + 1;

  logic [HI_W-1:0] hi;

  always_comb begin
    hi     = va[VA_W-1:IMPL_BITS-1];
    canon  = (&hi) | ~(|hi);
    sp_hit = va[VA_W-1] && (va[SP_TAG_LO+1:SP_TAG_LO] == 2'b10);
    sp_pa  = '0;
    sp_pa[SP_LOW_BITS-1:0] = va[SP_LOW_BITS-1:0];
    sp_pa[SP_RELOC]        = va[SP_LOW_BITS];
  end
endmodule

// File: rtl/vat_index.sv
module vat_index #(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W      = 10,
  parameter int LEVELS     = 3,
  parameter int LVL_W      = 2
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slice [LEVELS];

  // level 0 uses the highest field, the leaf level the lowest
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = va[PAGE_SHIFT + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (lvl == LVL_W'(k)) idx = slice[k];
    end
  end
endmodule

// File: rtl/vat_leaf.sv
module vat_leaf
  import vat_pkg::*;
#(
  parameter int PTE_W   = 64,
  parameter int MODE_W  = 2,
  parameter int RD_BASE = 8,
  parameter int WR_BASE = 12
) (
  input  logic [PTE_W-1:0]  pte,
  input  logic [MODE_W-1:0] mode,
  input  logic [2:0]        need,
  output logic [2:0]        prot,
  output vat_fault_e        fault
);
  localparam int PW = $clog2(PTE_W);

  logic [PW-1:0] rd_pos, wr_pos;
  logic          rd_en, wr_en;
  logic [2:0]    raw, kept;

  always_comb begin
    rd_pos = PW'(RD_BASE) + PW'(mode);
    wr_pos = PW'(WR_BASE) + PW'(mode);
    rd_en  = pte[rd_pos];
    wr_en  = pte[wr_pos];
    raw    = {rd_en, wr_en, rd_en};
    // each fault-on bit sits one above its permission position
    kept   = raw & ~pte[3:1];
    prot   = kept;
    fault  = FLT_NONE;
    if (need != 3'b000 && (raw & need) == 3'b000) begin
      fault = FLT_ACV;
      prot  = raw;
    end else if (need != 3'b000 && (kept & need) == 3'b000) begin
      if (need[2])      fault = FLT_FOE;
      else if (need[1]) fault = FLT_FOW;
      else              fault = FLT_FOR;
    end
  end
endmodule

// File: rtl/vat_walker.sv
module vat_walker
  import vat_pkg::*;
#(
  parameter int VA_W        = 64,
  parameter int PTE_W       = 64,
  parameter int PAGE_SHIFT  = 13,
  parameter int IDX_W       = 10,
  parameter int LEVELS      = 3,
  parameter int MODE_W      = 2,
  parameter int FRAME_LSB   = 32,
  parameter int RD_BASE     = 8,
  parameter int WR_BASE     = 12,
  parameter int SP_TAG_LO   = 41,
  parameter int SP_LOW_BITS = 40,
  parameter int SP_RELOC    = 43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       va,
  input  logic [1:0]        acc,
  input  logic [1:0]        mode,
  input  logic [63:0]       ptbr,
  output logic              done,
  output logic [63:0]       pa,
  output logic [2:0]        prot,
  output logic [2:0]        fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [63:0]       mem_rsp_data
);
  localparam int IMPL_BITS   = PAGE_SHIFT + LEVELS*IDX_W;
  localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int FRAME_W     = PTE_W - FRAME_LSB;
  localparam int ENTRY_SHIFT = $clog2(PTE_W/8);
  localparam logic [MODE_W-1:0] KERNEL = '0;

  vat_state_e        state;
  logic [VA_W-1:0]   va_q, base_q, pa_q;
  logic [2:0]        need_q, prot_q;
  logic [MODE_W-1:0] mode_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              done_q;
  vat_fault_e        fault_q;

  logic              canon, sp_hit;
  logic [VA_W-1:0]   sp_pa;
  logic [IDX_W-1:0]  idx;
  logic [2:0]        leaf_prot;
  vat_fault_e        leaf_fault;
  logic [VA_W-1:0]   frame_base;
  logic              rsp_fire, last_lvl;

  vat_region #(
    .VA_W(VA_W), .IMPL_BITS(IMPL_BITS), .SP_TAG_LO(SP_TAG_LO),
    .SP_LOW_BITS(SP_LOW_BITS), .SP_RELOC(SP_RELOC)
  ) u_region (
    .va(va), .canon(canon), .sp_hit(sp_hit), .sp_pa(sp_pa)
  );

  vat_index #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_index (
    .va(va_q), .lvl(lvl_q), .idx(idx)
  );

  vat_leaf #(
    .PTE_W(PTE_W), .MODE_W(MODE_W), .RD_BASE(RD_BASE), .WR_BASE(WR_BASE)
  ) u_leaf (
    .pte(mem_rsp_data), .mode(mode_q), .need(need_q),
    .prot(leaf_prot), .fault(leaf_fault)
  );

  always_comb begin
    frame_base = {{(VA_W-FRAME_W){1'b0}}, mem_rsp_data[PTE_W-1:FRAME_LSB]} << PAGE_SHIFT;
    rsp_fire   = (state == S_WAIT) && mem_rsp_valid;
    last_lvl   = (lvl_q == LVL_W'(LEVELS-1));
  end

  assign mem_req_valid = (state == S_ISSUE);
  assign mem_req_addr  = base_q + ({{(VA_W-IDX_W){1'b0}}, idx} << ENTRY_SHIFT);
  assign mem_rsp_ready = (state == S_WAIT);
  assign done          = done_q;
  assign pa            = pa_q;
  assign prot          = prot_q;
  assign fault         = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      need_q  <= '0;
      prot_q  <= '0;
      mode_q  <= '0;
      lvl_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            va_q   <= va;
            need_q <= acc_to_need(acc);
            mode_q <= mode;
            lvl_q  <= '0;
            base_q <= ptbr;
            if (!canon) begin
              done_q  <= 1'b1;
              fault_q <= FLT_ACV;
              pa_q    <= '0;
              prot_q  <= '0;
            end else if (sp_hit) begin
              done_q <= 1'b1;
              if (mode != KERNEL) begin
                fault_q <= FLT_ACV;
                pa_q    <= '0;
                prot_q  <= '0;
              end else begin
                fault_q <= FLT_NONE;
                pa_q    <= sp_pa;
                prot_q  <= 3'b111;
              end
            end else begin
              state <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          if (mem_req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_data[0]) begin
              state   <= S_IDLE;
              done_q  <= 1'b1;
              fault_q <= FLT_TNV;
              pa_q    <= '0;
              prot_q  <= '0;
            end else if (!last_lvl) begin
              if (!mem_rsp_data[RD_BASE]) begin
                state   <= S_IDLE;
                done_q  <= 1'b1;
                fault_q <= FLT_ACV;
                pa_q    <= '0;
                prot_q  <= '0;
              end else begin
                base_q <= frame_base;
                lvl_q  <= lvl_q + 1'b1;
                state  <= S_ISSUE;
              end
            end else begin
              state   <= S_IDLE;
              done_q  <= 1'b1;
              fault_q <= leaf_fault;
              prot_q  <= leaf_prot;
              pa_q    <= frame_base | {{(VA_W-PAGE_SHIFT){1'b0}}, va_q[PAGE_SHIFT-1:0]};
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // request channel holds under back-pressure
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // non-kernel mode never enters the superpage window
  assert_sp_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && start && canon && sp_hit && (mode != KERNEL)
      |=> done && (fault == 3'd1));

  // a probe that reaches a valid leaf is always clean
  assert_probe_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && last_lvl && mem_rsp_data[0] && (need_q == 3'b000)
      |=> done && (fault == 3'd0));

  // a successful access carries the permission it needed
  assert_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault == 3'd0) && (need_q != 3'b000) |-> ((prot & need_q) != 3'b000));

  // a non-canonical start finishes without touching memory
  assert_noncanon_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && start && !canon |=> done && !mem_req_valid && (fault == 3'd1));
endmodule

// File: tb/sim_vat_walker.sv
module sim_vat_walker;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] va = '0;
  logic [1:0]  acc = '0;
  logic [1:0]  mode = '0;
  logic [63:0] ptbr = 64'h10000;
  logic        done;
  logic [63:0] pa;
  logic [2:0]  prot, fault;
  logic        req_valid, req_ready, rsp_valid, rsp_ready;
  logic [63:0] req_addr, rsp_data;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  vat_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .acc(acc),
    .mode(mode), .ptbr(ptbr), .done(done), .pa(pa), .prot(prot),
    .fault(fault), .mem_req_valid(req_valid), .mem_req_ready(req_ready),
    .mem_req_addr(req_addr), .mem_rsp_valid(rsp_valid),
    .mem_rsp_ready(rsp_ready), .mem_rsp_data(rsp_data)
  );

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [63:0]];
  logic [7:0]  tick = '0;
  int          reads = 0;
  logic [63:0] addr_log [256];

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  always @(posedge clk) begin
    tick      <= tick + 8'd1;
    req_ready <= (tick[1:0] != 2'b01) && (tick[2:0] != 3'b110);
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd(req_addr);
        addr_log[reads[7:0]] <= req_addr;
        reads <= reads + 1;
      end
    end
  end

  // back-pressure monitor (R10)
  logic        prev_stall = 1'b0;
  logic [63:0] prev_addr = '0;
  int          stalls = 0;
  int          hold_bad = 0;
  always @(negedge clk) begin
    if (rst_n && prev_stall && !(req_valid && req_addr == prev_addr)) hold_bad++;
    prev_stall = rst_n && req_valid && !req_ready;
    if (prev_stall) stalls++;
    prev_addr = req_addr;
  end

  // ---------------- helpers ----------------
  localparam logic [63:0] VA_OK  = 64'h0000_0002_0100_6018;
  localparam logic [63:0] A_L1   = 64'h10008;
  localparam logic [63:0] A_L2   = 64'h40010;
  localparam logic [63:0] A_L3   = 64'h60018;
  localparam logic [63:0] E_L1   = (64'h20 << 32) | 64'h101;
  localparam logic [63:0] E_L2   = (64'h30 << 32) | 64'h101;
  localparam logic [63:0] FRAME  = 64'h1234 << 32;
  localparam logic [63:0] PA_OK  = 64'h0246_8018;

  logic [63:0] r_pa;
  logic [2:0]  r_prot, r_fault;
  int          r_reads;
  int          r_first;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] v, input logic [1:0] a, input logic [1:0] m,
                      input bit poke_busy);
    int r0;
    bit seen;
    @(negedge clk);
    r0 = reads;
    r_first = r0;
    va = v; acc = a; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = done;
    if (poke_busy && !seen) begin
      @(negedge clk);
      va = 64'h0004_0000_0000_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = done;
    end
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      seen = done;
    end
    chk(seen, "R11 completion", {63'd0, seen}, 64'd1);
    r_pa = pa; r_prot = prot; r_fault = fault; r_reads = reads - r0;
    @(negedge clk);
    chk(!done, "R11 done one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic set_tables(input logic [63:0] leaf);
    mem[A_L1] = E_L1;
    mem[A_L2] = E_L2;
    mem[A_L3] = leaf;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(!done && !req_valid && fault == 3'd0, "R11 reset state",
        {61'd0, done, req_valid, 1'b0}, 64'd0);
  endtask

  task automatic t_noncanon;
    walk(64'h0004_0000_0000_0000, 2'd1, 2'd0, 1'b0);
    chk(r_fault == 3'd1, "R1 noncanon fault", {61'd0, r_fault}, 64'd1);
    chk(r_reads == 0, "R1 noncanon reads", 64'(r_reads), 64'd0);
    walk(64'h0000_0400_0000_0000, 2'd0, 2'd0, 1'b0);
    chk(r_fault == 3'd1, "R1 bit42 only", {61'd0, r_fault}, 64'd1);
  endtask

  task automatic t_superpage;
    walk(64'hFFFF_FD00_1234_5678, 2'd2, 2'd0, 1'b0);
    chk(r_fault == 3'd0, "R2 superpage fault", {61'd0, r_fault}, 64'd0);
    chk(r_pa == 64'h0000_0800_1234_5678, "R2 superpage pa", r_pa, 64'h0000_0800_1234_5678);
    chk(r_prot == 3'b111, "R2 superpage prot", {61'd0, r_prot}, 64'd7);
    chk(r_reads == 0, "R2 superpage reads", 64'(r_reads), 64'd0);
    walk(64'hFFFF_FC00_0000_1000, 2'd1, 2'd1, 1'b0);
    chk(r_fault == 3'd1, "R3 superpage user", {61'd0, r_fault}, 64'd1);
  endtask

  task automatic t_walk_ok;
    set_tables(FRAME | 64'h1101);
    walk(VA_OK, 2'd1, 2'd0, 1'b0);
    chk(r_fault == 3'd0, "R7 walk fault", {61'd0, r_fault}, 64'd0);
    chk(r_pa == PA_OK, "R7 walk pa", r_pa, PA_OK);
    chk(r_prot == 3'b111, "R7 walk prot", {61'd0, r_prot}, 64'd7);
    chk(r_reads == 3, "R4 read count", 64'(r_reads), 64'd3);
    chk(addr_log[r_first[7:0]] == A_L1, "R4 level1 addr", addr_log[r_first[7:0]], A_L1);
    chk(addr_log[8'(r_first+1)] == A_L2, "R4 level2 addr", addr_log[8'(r_first+1)], A_L2);
    chk(addr_log[8'(r_first+2)] == A_L3, "R4 level3 addr", addr_log[8'(r_first+2)], A_L3);
  endtask

  task automatic t_invalid;
    set_tables(FRAME | 64'h1101);
    mem[A_L1] = 64'h0;
    walk(VA_OK, 2'd1, 2'd0, 1'b0);
    chk(r_fault == 3'd2, "R5 level1 invalid", {61'd0, r_fault}, 64'd2);
    chk(r_reads == 1, "R5 stop after level1", 64'(r_reads), 64'd1);
    set_tables(FRAME | 64'h1100);
    walk(VA_OK, 2'd1, 2'd0, 1'b0);
    chk(r_fault == 3'd2, "R5 leaf invalid", {61'd0, r_fault}, 64'd2);
    chk(r_reads == 3, "R5 leaf reads", 64'(r_reads), 64'd3);
  endtask

  task automatic t_kre;
    set_tables(FRAME | 64'h1101);
    mem[A_L2] = (64'h30 << 32) | 64'h1;
    walk(VA_OK, 2'd0, 2'd0, 1'b0);
    chk(r_fault == 3'd1, "R6 level2 no kernel read", {61'd0, r_fault}, 64'd1);
    chk(r_reads == 2, "R6 stop after level2", 64'(r_reads), 64'd2);
  endtask

  task automatic t_user_mode;
    set_tables(FRAME | 64'h1101);
    walk(VA_OK, 2'd2, 2'd3, 1'b0);
    chk(r_fault == 3'd1, "R7 mode3 write denied", {61'd0, r_fault}, 64'd1);
    set_tables(FRAME | 64'h8001);
    walk(VA_OK, 2'd2, 2'd3, 1'b0);
    chk(r_fault == 3'd0, "R7 mode3 write granted", {61'd0, r_fault}, 64'd0);
    chk(r_prot == 3'b010, "R7 mode3 prot", {61'd0, r_prot}, 64'd2);
  endtask

  task automatic t_fault_on;
    set_tables(FRAME | 64'h1105);
    walk(VA_OK, 2'd2, 2'd0, 1'b0);
    chk(r_fault == 3'd4, "R8 fault on write", {61'd0, r_fault}, 64'd4);
    chk(r_prot == 3'b101, "R8 write removed", {61'd0, r_prot}, 64'd5);
    set_tables(FRAME | 64'h1109);
    walk(VA_OK, 2'd3, 2'd0, 1'b0);
    chk(r_fault == 3'd5, "R8 fault on execute", {61'd0, r_fault}, 64'd5);
    set_tables(FRAME | 64'h0103);
    walk(VA_OK, 2'd1, 2'd0, 1'b0);
    chk(r_fault == 3'd3, "R8 fault on read", {61'd0, r_fault}, 64'd3);
  endtask

  task automatic t_probe;
    set_tables(FRAME | 64'h0001);
    walk(VA_OK, 2'd0, 2'd0, 1'b0);
    chk(r_fault == 3'd0, "R9 probe no perms", {61'd0, r_fault}, 64'd0);
    chk(r_prot == 3'b000, "R9 probe prot", {61'd0, r_prot}, 64'd0);
    set_tables(FRAME | 64'h110F);
    walk(VA_OK, 2'd0, 2'd0, 1'b0);
    chk(r_fault == 3'd0, "R9 probe all removed", {61'd0, r_fault}, 64'd0);
  endtask

  task automatic t_busy;
    set_tables(FRAME | 64'h1101);
    walk(VA_OK, 2'd1, 2'd0, 1'b1);
    chk(r_fault == 3'd0, "R11 start ignored busy", {61'd0, r_fault}, 64'd0);
    chk(r_pa == PA_OK, "R11 busy pa", r_pa, PA_OK);
    chk(r_reads == 3, "R11 busy reads", 64'(r_reads), 64'd3);
    chk(stalls > 0, "R10 stalls seen", 64'(stalls), 64'd1);
    chk(hold_bad == 0, "R10 request hold", 64'(hold_bad), 64'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R11 watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noncanon();
    t_superpage();
    t_walk_ok();
    t_invalid();
    t_kre();
    t_user_mode();
    t_fault_on();
    t_probe();
    t_busy();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule